// File: doc/BRIEF.md
# March Algorithm Self-Test Sequencer

This block is a self-test engine for a single-port RAM that is one bit wide and has a parameterised number of cells. After a start pulse it drives the RAM's address, write enable, write data and read strobe. It steps through the march elements of the algorithm picked on `alg_sel`. Each element has a direction, increasing or decreasing. At every cell it applies the element's whole list of reads and writes before the address moves on. Every read returns its data one cycle later, and that data is compared with the value the operation expects.

Six algorithms are built in: MATS, MATS+, MATS++, March X, March C-- and March Y. Some elements may run in either order, and these run upward. The elements that read x and write the complement keep the directions the algorithms give them. This is what lets the test catch address decoder faults. A mismatch sets a sticky fail flag. The first failing address, element index and operation index are captured. The test always runs to its last operation, then pulses `done`.

Top module: `march_bist`

## Requirements
- R1: While reset is held and afterwards until the first start, busy, done, fail, mem_we and mem_re are all 0.
- R2: Each running cycle issues exactly one operation: a read sets mem_re=1 and mem_we=0, and a write sets mem_we=1, mem_re=0 and mem_wdata to the written bit. All operations of an element go to one cell before the address moves. An upward element visits 0 to DEPTH-1, and a downward element visits DEPTH-1 down to 0.
- R3: alg_sel 0 runs MATS {up(w0); up(r0,w1); up(r1)}. alg_sel 1 runs MATS+ {up(w0); up(r0,w1); down(r1,w0)}. alg_sel 2 runs MATS++ {up(w0); up(r0,w1); down(r1,w0,r0)}.
- R4: alg_sel 3 runs March X {up(w0); up(r0,w1); down(r1,w0); up(r0)}. alg_sel 4 runs March C-- {up(w0); up(r0,w1); up(r1,w0); down(r0,w1); down(r1,w0); up(r0)}. alg_sel 5 runs March Y {up(w0); up(r0,w1,r1); down(r1,w0,r0); up(r0)}.
- R5: alg_sel values 6 and 7 run MATS. The select is taken only on the accepted start, so changing it during a run has no effect.
- R6: The first operation appears the cycle after start is accepted. busy stays high for k*DEPTH+1 cycles, where k is 4, 5, 6, 6, 10 or 8 for R3/R4's algorithms in order. done is high for exactly one cycle, the first cycle with busy low.
- R7: mem_rdata is compared in the cycle after mem_re. A mismatch sets fail, which holds until the next accepted start clears it. fail is final when done is high.
- R8: On the first mismatch only, fail_addr, fail_elem (element number from 0) and fail_op (position within the element from 0) capture that read's coordinates.
- R9: A start while busy is ignored, and the running sequence continues unchanged.
- R10: mem_we and mem_re are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a test when idle |
| alg_sel | input | 3 | Algorithm select, latched on start |
| mem_rdata | input | 1 | RAM read data, valid one cycle after mem_re |
| mem_addr | output | AW | RAM address |
| mem_we | output | 1 | RAM write enable |
| mem_wdata | output | 1 | RAM write data |
| mem_re | output | 1 | RAM read strobe |
| busy | output | 1 | Test in progress |
| done | output | 1 | One-cycle end-of-test pulse |
| fail | output | 1 | Sticky mismatch flag |
| fail_addr | output | AW | Address of first mismatch |
| fail_elem | output | 3 | Element index of first mismatch |
| fail_op | output | 2 | Operation index of first mismatch |

## Verification
The checker assumes that start and alg_sel are driven synchronously. It also assumes that mem_rdata comes from a RAM with exactly one cycle of read latency, so the capture properties only judge data returned on that schedule. The bench keeps to this by modelling the RAM as a registered array, with an optional stuck cell. It changes inputs only on falling edges and pulses start for a single cycle, except where a second start during a run is the stimulus under test.

// File: rtl/march_pkg.sv
package march_pkg;
  localparam int ELEM_W = 3;
  localparam int OPI_W  = 2;

  // bit1: write, bit0: data value (written or expected)
  typedef enum logic [1:0] {OP_R0 = 2'b00, OP_R1 = 2'b01, OP_W0 = 2'b10, OP_W1 = 2'b11} op_t;

  typedef struct packed {
    logic       down;
    logic [1:0] nops;
    op_t        op2;
    op_t        op1;
    op_t        op0;
  } elem_t;

  function automatic elem_t mk(input logic dn, input logic [1:0] n,
                               input op_t a, input op_t b, input op_t c);
    elem_t e;
    e.down = dn; e.nops = n; e.op0 = a; e.op1 = b; e.op2 = c;
    return e;
  endfunction

  function automatic op_t pick(input elem_t e, input logic [OPI_W-1:0] i);
    case (i)
      2'd0:    return e.op0;
      2'd1:    return e.op1;
      default: return e.op2;
    endcase
  endfunction

  function automatic logic [ELEM_W-1:0] n_elems(input logic [2:0] alg);
    case (alg)
      3'd3, 3'd5: return 3'd4;
      3'd4:       return 3'd6;
      default:    return 3'd3;
    endcase
  endfunction

  function automatic elem_t elem_at(input logic [2:0] alg, input logic [ELEM_W-1:0] idx);
    elem_t w0u, r0w1u;
    w0u   = mk(1'b0, 2'd1, OP_W0, OP_R0, OP_R0);
    r0w1u = mk(1'b0, 2'd2, OP_R0, OP_W1, OP_R0);
    if (idx == 3'd0) return w0u;
    case (alg)
      3'd1: return (idx == 3'd1) ? r0w1u : mk(1'b1, 2'd2, OP_R1, OP_W0, OP_R0);
      3'd2: return (idx == 3'd1) ? r0w1u : mk(1'b1, 2'd3, OP_R1, OP_W0, OP_R0);
      3'd3: case (idx)
              3'd1:    return r0w1u;
              3'd2:    return mk(1'b1, 2'd2, OP_R1, OP_W0, OP_R0);
              default: return mk(1'b0, 2'd1, OP_R0, OP_R0, OP_R0);
            endcase
      3'd4: case (idx)
              3'd1:    return r0w1u;
              3'd2:    return mk(1'b0, 2'd2, OP_R1, OP_W0, OP_R0);
              3'd3:    return mk(1'b1, 2'd2, OP_R0, OP_W1, OP_R0);
              3'd4:    return mk(1'b1, 2'd2, OP_R1, OP_W0, OP_R0);
              default: return mk(1'b0, 2'd1, OP_R0, OP_R0, OP_R0);
            endcase
      3'd5: case (idx)
              3'd1:    return mk(1'b0, 2'd3, OP_R0, OP_W1, OP_R1);
              3'd2:    return mk(1'b1, 2'd3, OP_R1, OP_W0, OP_R0);
              default: return mk(1'b0, 2'd1, OP_R0, OP_R0, OP_R0);
            endcase
      default: return (idx == 3'd1) ? r0w1u : mk(1'b0, 2'd1, OP_R1, OP_R0, OP_R0);
    endcase
  endfunction
endpackage

// File: rtl/march_addr.sv
module march_addr #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          load_down,
  input  logic          step,
  input  logic          down,
  output logic [AW-1:0] addr,
  output logic          at_end
);
  localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (rst)       addr <= '0;
    else if (load) addr <= load_down ? TOP : '0;
    else if (step) addr <= down ? addr - 1'b1 : addr + 1'b1;
  end

  assign at_end = down ? (addr == '0) : (addr == TOP);
endmodule

// File: rtl/march_seq.sv
module march_seq
  import march_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [2:0]        alg_sel,
  input  logic              at_end,
  output logic              busy,
  output logic              run,
  output logic              load,
  output logic              load_down,
  output logic              step,
  output logic              cur_down,
  output logic [ELEM_W-1:0] elem,
  output logic [OPI_W-1:0]  opi,
  output op_t               op,
  output logic              done
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} st_t;
  st_t        st;
  logic [2:0] alg_q;
  elem_t      cur;
  logic       last_op, last_elem;

  always_comb begin
    cur       = elem_at(alg_q, elem);
    op        = pick(cur, opi);
    cur_down  = cur.down;
    last_op   = (opi == cur.nops - 2'd1);
    last_elem = (elem == n_elems(alg_q) - 3'd1);
    run       = (st == S_RUN);
    busy      = (st != S_IDLE);
    load      = ((st == S_IDLE) && start) || (run && last_op && at_end && !last_elem);
    load_down = (st == S_IDLE) ? elem_at(alg_sel, '0).down
                               : elem_at(alg_q, ELEM_W'(elem + 3'd1)).down;
    step      = run && last_op && !at_end;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; alg_q <= '0; elem <= '0; opi <= '0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          alg_q <= alg_sel; elem <= '0; opi <= '0; st <= S_RUN;
        end
        S_RUN: begin
          if (!last_op) opi <= opi + 2'd1;
          else begin
            opi <= '0;
            if (at_end) begin
              if (last_elem) st <= S_FIN;
              else           elem <= elem + 3'd1;
            end
          end
        end
        default: begin
          st <= S_IDLE; done <= 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/march_cmp.sv
module march_cmp
  import march_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              rd_issue,
  input  logic              rd_exp,
  input  logic [AW-1:0]     rd_addr,
  input  logic [ELEM_W-1:0] rd_elem,
  input  logic [OPI_W-1:0]  rd_op,
  input  logic              rdata,
  output logic              fail,
  output logic [AW-1:0]     fail_addr,
  output logic [ELEM_W-1:0] fail_elem,
  output logic [OPI_W-1:0]  fail_op
);
  logic              vld_q, exp_q;
  logic [AW-1:0]     addr_q;
  logic [ELEM_W-1:0] elem_q;
  logic [OPI_W-1:0]  op_q;
  logic              miss;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0; exp_q <= 1'b0; addr_q <= '0; elem_q <= '0; op_q <= '0;
    end else begin
      vld_q <= rd_issue; exp_q <= rd_exp; addr_q <= rd_addr;
      elem_q <= rd_elem; op_q <= rd_op;
    end
  end

  assign miss = vld_q && (rdata != exp_q);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      fail <= 1'b0; fail_addr <= '0; fail_elem <= '0; fail_op <= '0;
    end else if (miss && !fail) begin
      fail <= 1'b1; fail_addr <= addr_q; fail_elem <= elem_q; fail_op <= op_q;
    end
  end
endmodule

// File: rtl/march_bist.sv
module march_bist
  import march_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [2:0]        alg_sel,
  input  logic              mem_rdata,
  output logic [AW-1:0]     mem_addr,
  output logic              mem_we,
  output logic              mem_wdata,
  output logic              mem_re,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [AW-1:0]     fail_addr,
  output logic [ELEM_W-1:0] fail_elem,
  output logic [OPI_W-1:0]  fail_op
);
  logic              run, load, load_down, step, cur_down, at_end;
  logic [ELEM_W-1:0] elem;
  logic [OPI_W-1:0]  opi;
  op_t               op;

  march_seq u_seq (
    .clk(clk), .rst(rst), .start(start), .alg_sel(alg_sel), .at_end(at_end),
    .busy(busy), .run(run), .load(load), .load_down(load_down), .step(step),
    .cur_down(cur_down), .elem(elem), .opi(opi), .op(op), .done(done)
  );

  march_addr #(.DEPTH(DEPTH)) u_addr (
    .clk(clk), .rst(rst), .load(load), .load_down(load_down), .step(step),
    .down(cur_down), .addr(mem_addr), .at_end(at_end)
  );

  assign mem_we    = run && op[1];
  assign mem_re    = run && !op[1];
  assign mem_wdata = op[0];

  march_cmp #(.AW(AW)) u_cmp (
    .clk(clk), .rst(rst), .clear(start && !busy), .rd_issue(mem_re),
    .rd_exp(op[0]), .rd_addr(mem_addr), .rd_elem(elem), .rd_op(opi),
    .rdata(mem_rdata), .fail(fail), .fail_addr(fail_addr),
    .fail_elem(fail_elem), .fail_op(fail_op)
  );
endmodule

// File: rtl/march_bist_chk.sv
module march_bist_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          mem_we,
  input logic          mem_re,
  input logic          busy,
  input logic          done,
  input logic          fail,
  input logic [AW-1:0] fail_addr,
  input logic [2:0]    fail_elem,
  input logic [1:0]    fail_op
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mem_we && !mem_re));
  p_rw_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && mem_re));
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_idle_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  p_fail_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (fail && !(start && !busy)) |=> fail);
  p_cap_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (fail && !(start && !busy)) |=> ($stable(fail_addr) && $stable(fail_elem) && $stable(fail_op)));
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> (busy || done));
endmodule

bind march_bist march_bist_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .mem_we(mem_we), .mem_re(mem_re),
  .busy(busy), .done(done), .fail(fail), .fail_addr(fail_addr),
  .fail_elem(fail_elem), .fail_op(fail_op)
);

// File: tb/march_bist_tb.sv
module march_bist_tb_top;
  localparam int DEPTH = 16;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [2:0] alg_sel = '0;
  logic mem_rdata = 1'b0;
  logic [AW-1:0] mem_addr, fail_addr;
  logic mem_we, mem_wdata, mem_re, busy, done, fail;
  logic [2:0] fail_elem;
  logic [1:0] fail_op;

  int total = 0, bad = 0, cyc = 0;
  int f_en = 0, f_a = 0, f_v = 0;
  logic ram [DEPTH];

  typedef struct { int addr; int we; int v; int elem; int op; } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  march_bist #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .start(start), .alg_sel(alg_sel), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_re(mem_re),
    .busy(busy), .done(done), .fail(fail), .fail_addr(fail_addr),
    .fail_elem(fail_elem), .fail_op(fail_op)
  );

  // one-cycle-latency RAM with optional stuck cell
  always @(posedge clk) begin
    if (mem_we) ram[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= (f_en != 0 && int'(mem_addr) == f_a) ? f_v[0] : ram[mem_addr];
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog: got %0d cycles expected under 150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input string act, input string exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: got %s expected %s", req, what, act, exp);
    end
  endtask

  // text form: U/D opens an element, then r0 r1 w0 w1 ops
  task automatic build(input string s);
    int ne = -1;
    int dirs[8]; int nop[8]; int ow[8][4]; int ov[8][4];
    q.delete();
    for (int i = 0; i < s.len(); i++) begin
      if (s[i] == "U" || s[i] == "D") begin
        ne++; dirs[ne] = (s[i] == "D") ? 1 : 0; nop[ne] = 0;
      end else if (s[i] == "r" || s[i] == "w") begin
        ow[ne][nop[ne]] = (s[i] == "w") ? 1 : 0;
        ov[ne][nop[ne]] = (s[i+1] == "1") ? 1 : 0;
        nop[ne]++; i++;
      end
    end
    for (int e = 0; e <= ne; e++)
      for (int k = 0; k < DEPTH; k++)
        for (int o = 0; o < nop[e]; o++) begin
          exp_t x;
          x.addr = (dirs[e] != 0) ? DEPTH - 1 - k : k;
          x.we = ow[e][o]; x.v = ov[e][o]; x.elem = e; x.op = o;
          q.push_back(x);
        end
  endtask

  task automatic run_alg(input int sel, input string req, input string s, input int kf,
                         input int fen, input int fa, input int fv, input bit poke);
    int m[DEPTH];
    int ef = 0, ea = 0, ee = 0, eo = 0, rd;
    bit seq_ok = 1;
    string act = "", expd = "";
    build(s);
    f_en = fen; f_a = fa; f_v = fv;
    foreach (m[i]) m[i] = 0;
    foreach (q[i]) begin
      if (q[i].we != 0) m[q[i].addr] = q[i].v;
      else begin
        rd = (fen != 0 && q[i].addr == fa) ? fv : m[q[i].addr];
        if (rd != q[i].v && ef == 0) begin
          ef = 1; ea = q[i].addr; ee = q[i].elem; eo = q[i].op;
        end
      end
    end
    check(q.size() == kf * DEPTH, "R6", "operation count",
          $sformatf("%0d", q.size()), $sformatf("%0d", kf * DEPTH));
    @(negedge clk); alg_sel = 3'(sel); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < q.size(); i++) begin
      if (i > 0) @(negedge clk);
      if (poke && i == 3) begin start = 1'b1; alg_sel = 3'(sel + 3); end
      if (poke && i == 4) start = 1'b0;
      if (seq_ok && !(busy && int'(mem_addr) == q[i].addr && int'(mem_we) == q[i].we &&
          mem_re == (q[i].we == 0) && (q[i].we == 0 || int'(mem_wdata) == q[i].v))) begin
        seq_ok = 0;
        act  = $sformatf("op%0d busy=%0d a=%0d we=%0d re=%0d wd=%0d", i, busy, mem_addr, mem_we, mem_re, mem_wdata);
        expd = $sformatf("a=%0d we=%0d d=%0d", q[i].addr, q[i].we, q[i].v);
      end
    end
    check(seq_ok, req, "operation stream (R2)", act, expd);
    @(negedge clk);
    check(busy && !mem_we && !mem_re && !done, "R6", "final busy cycle",
          $sformatf("busy=%0d we=%0d re=%0d done=%0d", busy, mem_we, mem_re, done), "busy=1 quiet");
    @(negedge clk);
    check(done && !busy, "R6", "done pulse", $sformatf("done=%0d busy=%0d", done, busy), "done=1 busy=0");
    check(int'(fail) == ef, "R7", "fail flag", $sformatf("%0d", fail), $sformatf("%0d", ef));
    if (ef != 0)
      check(int'(fail_addr) == ea && int'(fail_elem) == ee && int'(fail_op) == eo, "R8",
            "first failure", $sformatf("a=%0d e=%0d o=%0d", fail_addr, fail_elem, fail_op),
            $sformatf("a=%0d e=%0d o=%0d", ea, ee, eo));
    @(negedge clk);
    check(!done && !busy, "R6", "done one cycle", $sformatf("done=%0d", done), "0");
  endtask

  initial begin
    foreach (ram[i]) ram[i] = 1'b0;
    repeat (3) @(negedge clk);
    check(!busy && !done && !fail && !mem_we && !mem_re, "R1", "in reset",
          $sformatf("%0d%0d%0d%0d%0d", busy, done, fail, mem_we, mem_re), "00000");
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(!busy && !done && !fail && !mem_we && !mem_re, "R1", "after reset",
          $sformatf("%0d%0d%0d%0d%0d", busy, done, fail, mem_we, mem_re), "00000");
    run_alg(0, "R3", "Uw0 Ur0w1 Ur1", 4, 0, 0, 0, 0);
    run_alg(1, "R3", "Uw0 Ur0w1 Dr1w0", 5, 0, 0, 0, 0);
    run_alg(2, "R3", "Uw0 Ur0w1 Dr1w0r0", 6, 0, 0, 0, 0);
    run_alg(3, "R4", "Uw0 Ur0w1 Dr1w0 Ur0", 6, 0, 0, 0, 0);
    run_alg(4, "R4", "Uw0 Ur0w1 Ur1w0 Dr0w1 Dr1w0 Ur0", 10, 0, 0, 0, 0);
    run_alg(5, "R4", "Uw0 Ur0w1r1 Dr1w0r0 Ur0", 8, 0, 0, 0, 0);
    run_alg(6, "R5", "Uw0 Ur0w1 Ur1", 4, 0, 0, 0, 0);
    run_alg(7, "R5", "Uw0 Ur0w1 Ur1", 4, 0, 0, 0, 0);
    // R5/R9: start and select change mid-run are ignored
    run_alg(1, "R9", "Uw0 Ur0w1 Dr1w0", 5, 0, 0, 0, 1);
    // R7/R8: stuck-at-0 cell caught in the downward element
    run_alg(1, "R8", "Uw0 Ur0w1 Dr1w0", 5, 1, 5, 0, 0);
    // R8: stuck-at-1 cell, several mismatches, first one kept
    run_alg(4, "R8", "Uw0 Ur0w1 Ur1w0 Dr0w1 Dr1w0 Ur0", 10, 1, 9, 1, 0);
    run_alg(5, "R8", "Uw0 Ur0w1r1 Dr1w0r0 Ur0", 8, 1, 0, 0, 0);
    // R7: a new start clears the flag when the RAM is good
    run_alg(3, "R7", "Uw0 Ur0w1 Dr1w0 Ur0", 6, 0, 0, 0, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule